// File: doc/BRIEF.md
# Three-Tone Correlation Energy Meter

This block measures how much signal energy lies in three adjacent frequency bins of a real sample stream. Each accepted 16-bit signed sample is multiplied by the cosine and the sine of three on-chip reference tones. The six products are accumulated over a fixed block of samples. When the block closes, each accumulator is normalised by the block length, and the squared magnitudes of the three complex sums are added into a single energy figure. A calibration loop can use that figure as a cost value. It changes a correction setting, runs a measurement and compares the energies it gets back.

A one-cycle start pulse arms a measurement. Samples then arrive with a valid strobe, at no more than one per clock, and gaps are allowed. A one-cycle done pulse marks the energy output as fresh. The output keeps that value until the next done pulse. A build parameter can average the result over a power-of-two number of back-to-back blocks.

Top module: `tone_trio_energy`

## Requirements
- R1: While reset is held and after it is released, done_o is 0 and energy_o is 0.
- R2: For tone t with bin frequency f_t (64, 63, 65), the reference phase for the i-th accepted sample of a block is p = (i·f_t) mod 2048. The sine reference is trunc_toward_zero(sin(2πp/2048)·32767). The cosine reference is the sine reference at index (p+512) mod 2048. The index i restarts at 0 for every block.
- R3: Each product of sample and reference is arithmetic-shifted right by 15. The result is added to one of six 32-bit signed accumulators: a real part (cosine) and an imaginary part (sine) for each tone.
- R4: After 1024 accepted samples, each accumulator is arithmetic-shifted right by 10 (a floor division by 1024). The block energy is the sum of the squares of the six results, computed to 64 bits. The value presented on energy_o is saturated to 32 bits unsigned.
- R5: A sample is taken only in a measuring cycle in which smp_valid_i is 1. A cycle with smp_valid_i at 0 takes no sample. Samples offered while idle, in the start cycle or in the closing cycle after a block are ignored.
- R6: If the last sample of the last block is taken at the clock edge that ends cycle c, then done_o is 1 in cycle c+2 only, and energy_o carries the new result in that cycle. energy_o changes at no other time.
- R7: A start pulse clears all accumulators, phases, counters and the running total. It begins a new measurement even while another measurement is in progress, and the samples taken before it are discarded.
- R8: With AVG_LOG2 = n, 2^n blocks are measured back to back. The reported energy is the sum of their block energies shifted right by n. Between blocks there is one closing cycle in which samples are ignored.
- R9: done_o is never 1 in the cycle that directly follows a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin (or restart) a measurement |
| smp_valid_i | input | 1 | smp_i carries a sample this cycle |
| smp_i | input | 16 | Signed sample |
| done_o | output | 1 | One-cycle pulse: energy_o is fresh |
| energy_o | output | 32 | Combined three-bin energy, unsigned |

## Verification
The block has one pipeline stage after the accumulators: the closing cycle, in which the squares are summed. The energy result is therefore due two cycles after the cycle that carries the last sample. The bench drives inputs on falling edges and reads outputs on the falling edge that follows each rising edge. It expects done_o low in the closing cycle, high with the computed energy in the next cycle, and low again one cycle later with the energy unchanged. For averaged runs, the same count applies from the last sample of the final block, and a junk sample is placed in each closing cycle between blocks to show that it is not taken.

// File: rtl/tone_trio_energy.sv
module tone_trio_energy #(
  parameter int SW       = 16,
  parameter int AW       = 32,
  parameter int BLK_LOG2 = 10,
  parameter int PER_LOG2 = 11,
  parameter int F0       = 64,
  parameter int F1       = 63,
  parameter int F2       = 65,
  parameter int AVG_LOG2 = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 smp_valid_i,
  input  logic signed [SW-1:0] smp_i,
  output logic                 done_o,
  output logic [31:0]          energy_o
);
  localparam int PER  = 1 << PER_LOG2;
  localparam int QTR  = PER / 4;
  localparam int NBLK = 1 << AVG_LOG2;
  localparam int PW   = 2 * SW;
  localparam logic [1:0] S_IDLE = 2'd0, S_RUN = 2'd1, S_FIN = 2'd2;

  function automatic logic signed [SW-1:0] ref_sine(input int p);
    real ang;
    ang = 2.0 * 3.14159265358979 * real'(p) / real'(PER);
    return SW'($rtoi($sin(ang) * 32767.0));
  endfunction

  function automatic int tone_f(input int t);
    return (t == 0) ? F0 : ((t == 1) ? F1 : F2);
  endfunction

  logic signed [SW-1:0] rom [PER];
  for (genvar g = 0; g < PER; g++) begin : g_rom
    assign rom[g] = ref_sine(g);
  end

  logic [1:0]          state;
  logic [BLK_LOG2-1:0] cnt;
  logic [AVG_LOG2:0]   blk;
  logic [63:0]         tot;
  logic [63:0]         sq [6];

  wire take = (state == S_RUN) && smp_valid_i && !start_i;
  wire clr  = start_i || (state == S_FIN);

  for (genvar t = 0; t < 3; t++) begin : g_tone
    logic [PER_LOG2-1:0] ph;
    logic signed [AW-1:0] a_re, a_im;
    wire signed [SW-1:0] c_ref = rom[ph + PER_LOG2'(QTR)];
    wire signed [SW-1:0] s_ref = rom[ph];
    wire signed [PW-1:0] p_re  = smp_i * c_ref;
    wire signed [PW-1:0] p_im  = smp_i * s_ref;
    wire signed [AW-1:0] n_re  = a_re >>> BLK_LOG2;
    wire signed [AW-1:0] n_im  = a_im >>> BLK_LOG2;
    wire signed [63:0]   x_re  = 64'(n_re);
    wire signed [63:0]   x_im  = 64'(n_im);

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        ph   <= '0;
        a_re <= '0;
        a_im <= '0;
      end else if (take) begin
        ph   <= ph + PER_LOG2'(tone_f(t));
        a_re <= a_re + AW'(p_re >>> 15);
        a_im <= a_im + AW'(p_im >>> 15);
      end
    end

    assign sq[2*t]   = x_re * x_re;
    assign sq[2*t+1] = x_im * x_im;
  end

  wire [63:0] blk_e  = sq[0] + sq[1] + sq[2] + sq[3] + sq[4] + sq[5];
  wire [63:0] tot_nx = tot + blk_e;
  wire [63:0] avg    = tot_nx >> AVG_LOG2;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      blk      <= '0;
      tot      <= '0;
      done_o   <= 1'b0;
      energy_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        state <= S_RUN;
        cnt   <= '0;
        blk   <= '0;
        tot   <= '0;
      end else begin
        case (state)
          S_RUN: if (take) begin
            cnt <= cnt + 1'b1;
            if (&cnt) state <= S_FIN;
          end
          S_FIN: if (blk == (AVG_LOG2+1)'(NBLK - 1)) begin
            energy_o <= (|avg[63:32]) ? 32'hFFFF_FFFF : avg[31:0];
            done_o   <= 1'b1;
            state    <= S_IDLE;
          end else begin
            blk   <= blk + 1'b1;
            tot   <= tot_nx;
            state <= S_RUN;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tte_props.sv
module tte_props (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic        done_o,
  input logic [31:0] energy_o,
  input logic [1:0]  state_q
);
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_after_close_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(state_q) == 2'd2);
  p_energy_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(energy_o) |-> done_o);
  p_idle_after_done_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> state_q == 2'd0);
  p_start_no_done_r9: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !done_o);
  p_start_arms_r7: assert property (@(posedge clk) disable iff (rst)
    start_i |=> state_q == 2'd1);
endmodule

bind tone_trio_energy tte_props u_props (
  .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
  .energy_o(energy_o), .state_q(state)
);

// File: tb/sim_tone_trio_energy.sv
module sim_tone_trio_energy;
  localparam real PI = 3.14159265358979;
  localparam int FR [3] = '{64, 63, 65};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start0 = 1'b0, start1 = 1'b0;
  logic valid = 1'b0;
  logic signed [15:0] data = '0;
  logic done0, done1;
  logic [31:0] en0, en1;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tone_trio_energy u0 (.clk(clk), .rst(rst), .start_i(start0), .smp_valid_i(valid),
    .smp_i(data), .done_o(done0), .energy_o(en0));
  tone_trio_energy #(.AVG_LOG2(1)) u1 (.clk(clk), .rst(rst), .start_i(start1),
    .smp_valid_i(valid), .smp_i(data), .done_o(done1), .energy_o(en1));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rsin(input int p);
    return $rtoi($sin(2.0 * PI * real'(p) / 2048.0) * 32767.0);
  endfunction

  function automatic int smp_of(input int pat, input int b, input int i);
    int x;
    case (pat)
      1: return $rtoi($cos(2.0 * PI * 64.0 * i / 2048.0) * 20000.0);
      2: return $rtoi($sin(2.0 * PI * 63.0 * i / 2048.0) * 30000.0);
      3: begin
        x = i * 40503 + b * 977 + i * i;
        return int'($signed(16'(x ^ (x >> 7))));
      end
      4: return -32768;
      5: return $rtoi(12000.0 * $cos(2.0 * PI * 65.0 * i / 2048.0)
                    + 9000.0 * $sin(2.0 * PI * 64.0 * i / 2048.0));
      6: return 32767;
      default: return 0;
    endcase
  endfunction

  function automatic longint blk_energy(input int pat, input int b);
    int ar [3];
    int ai [3];
    longint e;
    int s, p, re, im;
    for (int t = 0; t < 3; t++) begin ar[t] = 0; ai[t] = 0; end
    for (int i = 0; i < 1024; i++) begin
      s = smp_of(pat, b, i);
      for (int t = 0; t < 3; t++) begin
        p = (i * FR[t]) % 2048;
        ar[t] += (s * rsin((p + 512) % 2048)) >>> 15;
        ai[t] += (s * rsin(p)) >>> 15;
      end
    end
    e = 0;
    for (int t = 0; t < 3; t++) begin
      re = ar[t] >>> 10;
      im = ai[t] >>> 10;
      e += longint'(re) * re + longint'(im) * im;
    end
    return e;
  endfunction

  function automatic longint sat32(input longint e);
    return (e > 64'sh0FFFF_FFFF) ? 64'sh0FFFF_FFFF : e;
  endfunction

  task automatic feed_block(input int pat, input int b, input bit gaps);
    for (int i = 0; i < 1024; i++) begin
      if (gaps && (i % 5 == 2)) begin
        valid = 1'b0; data = -16'sd1;
        @(negedge clk);
      end
      valid = 1'b1; data = 16'(smp_of(pat, b, i));
      @(negedge clk);
    end
  endtask

  task automatic run0(input int pat, input bit gaps, input bit close_junk,
                      input bit idle_junk, input bit restart, input string req);
    longint exp;
    exp = sat32(blk_energy(pat, 0));
    if (idle_junk) begin
      for (int k = 0; k < 15; k++) begin
        valid = 1'b1; data = 16'(smp_of(3, 5, k));
        @(negedge clk);
      end
    end
    start0 = 1'b1; valid = 1'b1; data = 16'sd777;
    @(negedge clk);
    start0 = 1'b0;
    check(done0 == 1'b0, "R9 done after start", done0, 0);
    if (restart) begin
      for (int k = 0; k < 300; k++) begin
        valid = 1'b1; data = 16'(smp_of(3, 9, k));
        @(negedge clk);
      end
      start0 = 1'b1; valid = 1'b1; data = 16'sd555;
      @(negedge clk);
      start0 = 1'b0;
    end
    feed_block(pat, 0, gaps);
    valid = close_junk; data = 16'sd31000;
    check(done0 == 1'b0, {req, " R6 done early"}, done0, 0);
    @(negedge clk);
    valid = 1'b0;
    check(done0 == 1'b1, {req, " R6 done due"}, done0, 1);
    check(en0 == 32'(exp), {req, " energy"}, en0, exp);
    @(negedge clk);
    check(done0 == 1'b0, {req, " R6 done width"}, done0, 0);
    check(en0 == 32'(exp), {req, " R6 energy hold"}, en0, exp);
  endtask

  task automatic run1(input int pat, input string req);
    longint exp;
    exp = sat32((blk_energy(pat, 0) + blk_energy(pat, 1)) >>> 1);
    start1 = 1'b1; valid = 1'b0;
    @(negedge clk);
    start1 = 1'b0;
    feed_block(pat, 0, 1'b0);
    valid = 1'b1; data = 16'sd29000;
    @(negedge clk);
    feed_block(pat, 1, 1'b0);
    valid = 1'b0;
    check(done1 == 1'b0, {req, " R6 done early"}, done1, 0);
    @(negedge clk);
    check(done1 == 1'b1, {req, " R6 done due"}, done1, 1);
    check(en1 == 32'(exp), {req, " averaged energy"}, en1, exp);
    @(negedge clk);
    check(done1 == 1'b0, {req, " R6 done width"}, done1, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(done0 == 1'b0 && en0 == 32'd0, "R1 reset u0", en0, 0);
    rst = 1'b0;
    @(negedge clk);
    check(done0 == 1'b0 && done1 == 1'b0, "R1 done after reset", done0 | done1, 0);
    check(en0 == 32'd0 && en1 == 32'd0, "R1 energy after reset", en0 | en1, 0);
    run0(0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 zero input");
    run0(1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 R3 R4 cosine bin 64");
    run0(2, 1'b0, 1'b0, 1'b0, 1'b0, "R2 R3 sine bin 63");
    run0(5, 1'b0, 1'b0, 1'b0, 1'b0, "R2 R4 mixed bins 65/64");
    run0(3, 1'b0, 1'b0, 1'b0, 1'b0, "R3 R4 pseudo-random");
    run0(4, 1'b0, 1'b0, 1'b0, 1'b0, "R3 negative full scale");
    run0(6, 1'b0, 1'b0, 1'b0, 1'b0, "R3 positive full scale");
    run0(1, 1'b1, 1'b1, 1'b0, 1'b0, "R5 gaps and closing junk");
    run0(2, 1'b0, 1'b0, 1'b1, 1'b0, "R5 idle junk");
    run0(5, 1'b0, 1'b0, 1'b0, 1'b1, "R7 restart");
    run1(3, "R8 two-block random");
    run1(1, "R8 two-block tone");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule